// File: doc/BRIEF.md
# Periodic Interval Tick Timer

This block turns the master clock into a steady periodic tick for an operating-system time base. A fixed prescaler divides the clock by sixteen. Each prescaled step advances a 20-bit interval counter. When that counter has reached the programmed limit, the next step returns it to zero. That event, a wrap, marks one elapsed period. A wrap sets a pending flag, which can raise an interrupt. It also adds one to a 12-bit count of periods that software has not yet collected.

Software reads the timer in one of two ways. A destructive read, signalled by a one-cycle strobe, takes the current interval count and the elapsed-period count. It then clears the elapsed count and acknowledges the pending flag. A passive read samples the same two outputs without the strobe and changes nothing. Because the elapsed count keeps accumulating until it is read, a late handler still learns how many periods went by.

The mode settings are the limit, a run enable and an interrupt enable. They are loaded together by a single write. For a 1 ms tick, set the limit to clock_hz / 16 / 1000 − 1.

Top module: `tick_timer`

## Requirements
- R1: After reset, `cur_count`, `elapsed`, `tick_pending` and `irq` are all zero, and the timer is stopped.
- R2: While running, the interval counter advances by exactly one every 16 clock cycles. The first advance happens 17 cycles after the mode write that starts the timer, counting the write's own edge.
- R3: When the interval counter is at or above the limit and a prescaled step arrives, it returns to 0 instead of incrementing. With a steady limit L the period is (L+1)·16 cycles.
- R4: Each wrap adds one to `elapsed`. `elapsed` saturates at 4095 and never wraps to 0 on its own.
- R5: A cycle with `value_rd` high clears `elapsed` to 0 and clears `tick_pending` on the next edge. Without `value_rd`, both are preserved.
- R6: If `value_rd` coincides with a wrap, the read cycle still shows the old `elapsed`. Afterwards `elapsed` is exactly 1 and `tick_pending` stays set.
- R7: `tick_pending` is set by a wrap and stays set until a read clears it. `irq` equals `tick_pending` gated by the interrupt enable.
- R8: While the timer is stopped, the interval counter is held at 0 and the prescaler is reset. `elapsed` and `tick_pending` keep their values. On restart, timing starts again as in R2.
- R9: A write with `mode_we` high loads the limit, the run enable and the interrupt enable together. The new values take effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Loads the three mode fields |
| mode_limit | input | 20 | Interval limit L |
| mode_run | input | 1 | Timer run enable |
| mode_irq_en | input | 1 | Interrupt enable |
| value_rd | input | 1 | Destructive read strobe: clears elapsed and acknowledges |
| cur_count | output | 20 | Current interval count |
| elapsed | output | 12 | Periods since the last destructive read |
| tick_pending | output | 1 | Wrap not yet acknowledged |
| irq | output | 1 | Interrupt request |

## Verification
The bench tries the timer with the following patterns:
- A small steady limit, read by passive sampling, which separates the prescale length from the wrap point.
- Destructive reads at ordinary moments, then one aimed at the exact wrap edge, which distinguishes clear-then-count from count-then-clear ordering.
- A limit of zero held long enough to reach saturation, which separates saturation from wrap-around.
- A stop/restart, which shows whether the prescaler phase is really reset.
- A limit lowered below the running count and the interrupt enable dropped, which separate the at-or-above wrap from an equality compare and show that the enable only gates the request.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned CNT_W_DEF = 20;
  localparam int unsigned PER_W_DEF = 12;
  localparam int unsigned PRE_W_DEF = 4;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = tick_pkg::PRE_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe
);
  localparam logic [PRE_W-1:0] LAST = '1;
  logic [PRE_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (!run) phase <= '0;
    else           phase <= phase + 1'b1;
  end

  assign strobe = run && (phase == LAST);
endmodule

// File: rtl/tick_interval_ctr.sv
module tick_interval_ctr #(
  parameter int unsigned CNT_W = tick_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = run && step && (count >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!run)    count <= '0;
    else if (wrap)    count <= '0;
    else if (step)    count <= count + 1'b1;
  end
endmodule

// File: rtl/tick_period_ctr.sv
module tick_period_ctr #(
  parameter int unsigned PER_W = tick_pkg::PER_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             rd,
  output logic [PER_W-1:0] periods
);
  localparam logic [PER_W-1:0] TOP = '1;
  logic [PER_W-1:0] base;

  always_comb base = rd ? '0 : periods;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     periods <= '0;
    else if (wrap && (base != TOP)) periods <= base + 1'b1;
    else                            periods <= base;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned CNT_W = tick_pkg::CNT_W_DEF,
  parameter int unsigned PER_W = tick_pkg::PER_W_DEF,
  parameter int unsigned PRE_W = tick_pkg::PRE_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [CNT_W-1:0] mode_limit,
  input  logic             mode_run,
  input  logic             mode_irq_en,
  input  logic             value_rd,
  output logic [CNT_W-1:0] cur_count,
  output logic [PER_W-1:0] elapsed,
  output logic             tick_pending,
  output logic             irq
);
  logic [CNT_W-1:0] limit_q;
  logic             run_q;
  logic             ien_q;
  logic             step;
  logic             wrap;
  logic             pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
    end else if (mode_we) begin
      limit_q <= mode_limit;
      run_q   <= mode_run;
      ien_q   <= mode_irq_en;
    end
  end

  tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .strobe(step)
  );

  tick_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run_q), .step(step),
    .limit(limit_q), .count(cur_count), .wrap(wrap)
  );

  tick_period_ctr #(.PER_W(PER_W)) u_per (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .rd(value_rd), .periods(elapsed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (wrap)     pend_q <= 1'b1;
    else if (value_rd) pend_q <= 1'b0;
  end

  assign tick_pending = pend_q;
  assign irq          = pend_q && ien_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned PER_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             step,
  input logic             wrap,
  input logic             value_rd,
  input logic [CNT_W-1:0] cur_count,
  input logic [PER_W-1:0] elapsed,
  input logic             tick_pending,
  input logic             irq
);
  localparam logic [PER_W-1:0] TOP = '1;

  // R2
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !step) |=> $stable(cur_count));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cur_count == '0));

  // R4
  period_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !value_rd && elapsed != TOP) |=> (elapsed == $past(elapsed) + 1'b1));

  // R4
  period_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed == TOP && !value_rd) |=> (elapsed == TOP));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (value_rd && !wrap) |=> (elapsed == '0 && !tick_pending));

  // R6
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (value_rd && wrap) |=> (elapsed == 1 && tick_pending));

  // R7
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tick_pending);

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cur_count == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .step(step), .wrap(wrap),
  .value_rd(value_rd), .cur_count(cur_count), .elapsed(elapsed),
  .tick_pending(tick_pending), .irq(irq)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int CLK_NS = 10;
  localparam int LIMIT_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [19:0] mode_limit = '0;
  logic        mode_run = 1'b0;
  logic        mode_irq_en = 1'b0;
  logic        value_rd = 1'b0;
  logic [19:0] cur_count;
  logic [11:0] elapsed;
  logic        tick_pending;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_pre = 0, m_cnt = 0, m_pc = 0, m_int = 0;
  bit m_pend = 0, m_en = 0, m_ien = 0;

  always #(CLK_NS/2) clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_limit(mode_limit),
    .mode_run(mode_run), .mode_irq_en(mode_irq_en), .value_rd(value_rd),
    .cur_count(cur_count), .elapsed(elapsed), .tick_pending(tick_pending), .irq(irq)
  );

  function automatic bit wrap_next();
    return m_en && m_pre == 15 && m_cnt >= m_int;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_pc = 0; m_int = 0;
      m_pend = 0; m_en = 0; m_ien = 0;
    end else begin
      bit stb, wr;
      stb = m_en && m_pre == 15;
      wr  = stb && m_cnt >= m_int;
      if (!m_en) begin
        m_pre = 0; m_cnt = 0;
      end else begin
        m_pre = (m_pre + 1) % 16;
        if (stb) m_cnt = wr ? 0 : m_cnt + 1;
      end
      if (value_rd) m_pc = 0;
      if (wr && m_pc < 4095) m_pc = m_pc + 1;
      if (wr) m_pend = 1;
      else if (value_rd) m_pend = 0;
      if (mode_we) begin
        m_int = int'(mode_limit); m_en = mode_run; m_ien = mode_irq_en;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 count vs model", int'(cur_count), m_cnt);
      check("R4 elapsed vs model", int'(elapsed), m_pc);
      check("R7 pending vs model", int'(tick_pending), int'(m_pend));
      check("R7 irq vs model", int'(irq), int'(m_pend && m_ien));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT_CYC && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT_CYC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(int lim, bit run, bit ien);
    mode_limit = 20'(lim); mode_run = run; mode_irq_en = ien; mode_we = 1'b1;
    tick(1);
    mode_we = 1'b0;
  endtask

  task automatic do_read();
    value_rd = 1'b1;
    tick(1);
    value_rd = 1'b0;
  endtask

  initial begin
    int old;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R1
    check("R1 count", int'(cur_count), 0);
    check("R1 elapsed", int'(elapsed), 0);
    check("R1 pending", int'(tick_pending), 0);
    check("R1 irq", int'(irq), 0);

    // R9 / R2: start with limit 3
    write_mode(3, 1, 1);
    tick(15);
    check("R2 no step yet", int'(cur_count), 0);
    tick(1);
    check("R2 first step", int'(cur_count), 1);
    tick(48);
    check("R3 first wrap count", int'(cur_count), 0);
    check("R4 first wrap elapsed", int'(elapsed), 1);
    check("R7 irq after wrap", int'(irq), 1);
    tick(30);
    // R5: passive sampling leaves state
    check("R5 image keeps elapsed", int'(elapsed), 1);
    check("R5 image keeps pending", int'(tick_pending), 1);
    do_read();
    check("R5 read clears elapsed", int'(elapsed), 0);
    check("R5 read clears pending", int'(tick_pending), 0);

    // R6: read aimed at the wrap edge
    while (!wrap_next()) tick(1);
    old = int'(elapsed);
    check("R6 old value shown", old, m_pc);
    do_read();
    check("R6 one tick left", int'(elapsed), 1);
    check("R6 pending kept", int'(tick_pending), 1);

    // R8: stop and restart
    write_mode(3, 0, 1);
    tick(1);
    check("R8 stopped count", int'(cur_count), 0);
    check("R8 elapsed kept", int'(elapsed), 1);
    tick(40);
    check("R8 still zero", int'(cur_count), 0);
    write_mode(3, 1, 1);
    tick(15);
    check("R8 restart no step", int'(cur_count), 0);
    tick(1);
    check("R8 restart first step", int'(cur_count), 1);

    // R3: lower limit below the running count
    write_mode(7, 1, 1);
    while (cur_count != 5) tick(1);
    write_mode(2, 1, 0);
    while (m_pre != 15) tick(1);
    tick(1);
    check("R3 shrink wraps", int'(cur_count), 0);
    // R7: enable off gates request only
    check("R7 pending with ien off", int'(tick_pending), 1);
    check("R7 irq gated", int'(irq), 0);

    // R4: saturation with limit 0
    do_read();
    write_mode(0, 1, 1);
    tick(4100 * 16);
    check("R4 saturated", int'(elapsed), 4095);
    tick(64);
    check("R4 stays saturated", int'(elapsed), 4095);
    do_read();
    check("R5 read after saturation", int'(elapsed) <= 1 ? 1 : 0, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule